// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block guards a processor against runaway code. It counts ticks of a chosen timebase and raises a reset request once a programmed number of ticks has passed without software restarting it. The timebase is either a slow sub-clock, delivered as a single-cycle strobe synchronous to the block clock, or the block clock itself divided by four. A static configuration input picks between the two. Everything runs on one clock, and enable strobes take the place of derived clocks.

Software controls the timer through one 8-bit control byte, which has a write strobe and a read-back port. The upper bit is not used by the timer. It is passed out as the level that keeps the system clock running during idle. Three bits choose one of eight power-of-two timeouts. Four bits form a key field: one exact pattern stops the timer, and every other pattern lets it run. Because of this, a stray write is far more likely to leave the watchdog running than to turn it off. A clear strobe restarts the count at any time.

Top module: `keyed_wdt`

## Requirements
- R1: In the cycle after a synchronous reset, `ctrl_rdata` reads 0x7A and `wdt_rst_req` is 0. This leaves the timer stopped with the longest timeout selected.
- R2: When `ctrl_we` is 1 at a clock edge, all eight bits of `ctrl_wdata` are stored, and `ctrl_rdata` shows them from the next cycle on.
- R3: `idle_sysclk_on` always equals bit 7 of the control byte. A value of 1 keeps the system clock running in idle.
- R4: When the key field, bits 3:0, holds exactly 4'b1010, the count is held at zero and no reset request is produced. Any other key value lets the timer run.
- R5: The timeout field, bits 6:4, holds a value s from 0 to 7. The timeout is then 2^(13+s) timebase ticks. With the default parameters this spans 2^13 to 2^20 ticks.
- R6: A timeout produces a `wdt_rst_req` pulse that lasts exactly one cycle, and counting restarts from zero. Successive pulses are exactly one timeout period apart.
- R7: When `src_sel` is 0, each cycle with `sub_tick` high is one tick. When `src_sel` is 1, a free-running divide-by-four prescaler supplies one tick every fourth clock, with the first tick in the fourth cycle after reset.
- R8: A `sw_clr` pulse sets the count to zero, and no timeout is reported in that cycle.
- R9: A write that changes the timeout field sets the count to zero in the same cycle. A write that leaves the field unchanged does not disturb the count.
- R10: When the timer goes from stopped to running, counting starts from zero, so the first request comes a full timeout period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the system clock) |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Timebase select: 0 = sub-clock strobe, 1 = clock divided by four |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period |
| sw_clr | input | 1 | Software restart of the count |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte read-back |
| idle_sysclk_on | output | 1 | Keep the system clock running in idle (bit 7) |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The timer is first left at its reset key. A run of disabled cycles then shows that the 1010 pattern really stops it. Several running keys are tried against three timeout selections, one of them the longest. Measuring the gap between successive requests separates a correct power-of-two span from an off-by-one or a wrong bit slice. The same timeout is driven once from the divided clock and once from a sub-clock strobe every third cycle, which shows that the source selection and the prescaler phase are correct. Periodic clears, a change of the timeout field, and a stop/start sequence made after a long run show whether each restart really returns the count to zero. A behavioural model is compared with the design on every clock.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    localparam int SEL_W = 3;
    localparam int KEY_W = 4;
    localparam logic [KEY_W-1:0] STOP_KEY = 4'b1010;

    typedef struct packed {
        logic             idle_on;
        logic [SEL_W-1:0] span_sel;
        logic [KEY_W-1:0] key;
    } wdt_ctrl_t;

    localparam wdt_ctrl_t CTRL_RST = '{idle_on: 1'b0, span_sel: 3'b111, key: STOP_KEY};

    function automatic logic key_runs(input logic [KEY_W-1:0] k);
        return k != STOP_KEY;
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    assign tick = &pre_q;

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output wdt_ctrl_t  ctrl,
    output logic       span_chg
);
    wdt_ctrl_t ctrl_q;
    wdt_ctrl_t wr_view;

    assign wr_view = wdata;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= CTRL_RST;
        else if (we) ctrl_q <= wr_view;
    end

    assign ctrl     = ctrl_q;
    assign span_chg = we && (wr_view.span_sel != ctrl_q.span_sel);

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (ctrl_q == $past(wr_view)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int MIN_EXP = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [SEL_W-1:0] span_sel,
    output logic             fire
);
    localparam int TOP_EXP = MIN_EXP + (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_mask;
    logic             at_term;
    logic             fire_q;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            term_mask[i] = (i < (MIN_EXP + int'(span_sel)));
        end
    end

    assign at_term = (cnt_q & term_mask) == term_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (!run || restart) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (at_term) begin
                    cnt_q  <= '0;
                    fire_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign fire = fire_q;

    initial begin
        width_ok_chk: assert (CNT_W >= TOP_EXP);
    end

    // R6
    one_cycle_req_chk: assert property (@(posedge clk) disable iff (rst) fire_q |=> !fire_q);
    // R4
    stop_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0) && !fire_q);
    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0) && !fire_q);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int MIN_EXP = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_sel,
    input  logic       sub_tick,
    input  logic       sw_clr,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    output logic       idle_sysclk_on,
    output logic       wdt_rst_req
);
    wdt_ctrl_t ctrl;
    logic      span_chg;
    logic      sys_tick;
    logic      tick;
    logic      run;

    wdt_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .we       (ctrl_we),
        .wdata    (ctrl_wdata),
        .ctrl     (ctrl),
        .span_chg (span_chg)
    );

    wdt_prescale #(.PRE_W(2)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (sys_tick)
    );

    assign tick = src_sel ? sys_tick : sub_tick;
    assign run  = key_runs(ctrl.key);

    wdt_counter #(.CNT_W(CNT_W), .MIN_EXP(MIN_EXP)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tick),
        .restart  (sw_clr || span_chg),
        .span_sel (ctrl.span_sel),
        .fire     (wdt_rst_req)
    );

    assign ctrl_rdata     = ctrl;
    assign idle_sysclk_on = ctrl.idle_on;

    // R1
    reset_val_chk: assert property (@(posedge clk) rst |=> (ctrl_rdata == 8'h7A) && !wdt_rst_req);
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
    localparam int CW = 10;
    localparam int ME = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_sel = 1'b1;
    logic sub_tick = 1'b0;
    logic sw_clr = 1'b0;
    logic ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic idle_sysclk_on;
    logic wdt_rst_req;

    always #4 clk = ~clk;

    keyed_wdt #(.CNT_W(CW), .MIN_EXP(ME)) u_keyed_wdt (
        .clk(clk), .rst(rst), .src_sel(src_sel), .sub_tick(sub_tick),
        .sw_clr(sw_clr), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .idle_sysclk_on(idle_sysclk_on),
        .wdt_rst_req(wdt_rst_req)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    int last_pulse = 0;
    int gap = 0;
    bit sub_auto = 1'b0;
    int sub_phase = 0;

    // behavioural reference
    logic [7:0] m_reg = 8'h7A;
    int m_cnt = 0;
    int m_pre = 0;
    bit m_req = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit tk;
        bit en;
        bit chg;
        if (rst) begin
            m_reg = 8'h7A; m_cnt = 0; m_pre = 0; m_req = 0;
        end else begin
            tk  = src_sel ? (m_pre == 3) : sub_tick;
            m_pre = (m_pre + 1) % 4;
            en  = (m_reg[3:0] != 4'b1010);
            chg = ctrl_we && (ctrl_wdata[6:4] != m_reg[6:4]);
            m_req = 0;
            if (!en || sw_clr || chg) m_cnt = 0;
            else if (tk) begin
                if (m_cnt == (1 << (ME + int'(m_reg[6:4]))) - 1) begin
                    m_req = 1; m_cnt = 0;
                end else m_cnt++;
            end
            if (ctrl_we) m_reg = ctrl_wdata;
        end
    end

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (!rst) begin
            check(ctrl_rdata == m_reg, "R2 readback", int'(ctrl_rdata), int'(m_reg));
            check(idle_sysclk_on == m_reg[7], "R3 idle bit", int'(idle_sysclk_on), int'(m_reg[7]));
            check(wdt_rst_req == m_req, "R5/R6 request", int'(wdt_rst_req), int'(m_req));
        end
        if (wdt_rst_req) begin
            pulses++;
            gap = cyc - last_pulse;
            last_pulse = cyc;
        end
    end

    // sub-clock strobe generator, every third cycle when enabled
    always @(negedge clk) begin
        if (sub_auto) begin
            sub_phase = (sub_phase + 1) % 3;
            sub_tick = (sub_phase == 0);
        end else sub_tick = 1'b0;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wait_pulses(input int n, input string req);
        int target;
        int spent;
        target = pulses + n;
        spent = 0;
        while (pulses < target && spent < 20000) begin
            @(negedge clk);
            spent++;
        end
        if (pulses < target) check(1'b0, {req, " watchdog expired"}, pulses, target);
    endtask

    initial begin
        int p0;
        step(3);
        rst = 1'b0;
        @(posedge clk); #2;
        // R1
        check(ctrl_rdata == 8'h7A, "R1 reset value", int'(ctrl_rdata), 8'h7A);
        check(wdt_rst_req == 1'b0, "R1 no request", int'(wdt_rst_req), 0);
        check(idle_sysclk_on == 1'b0, "R3 reset idle bit", int'(idle_sysclk_on), 0);

        // R4: stop key keeps timer quiet
        p0 = pulses;
        step(2000);
        check(pulses == p0, "R4 stopped by 1010", pulses - p0, 0);

        // R5 R6 R7: span 2^3 ticks from clock/4
        wr(8'h05);
        wait_pulses(3, "R6");
        check(gap == 32, "R5 R7 span sel0 divided clock", gap, 32);

        // R9: changing span restarts; sel1 doubles period
        wr(8'h15);
        wait_pulses(3, "R9");
        check(gap == 64, "R5 R9 span sel1", gap, 64);

        // R2 R3: same span, idle bit set, other running key
        wr(8'h93);
        step(2);
        check(ctrl_rdata == 8'h93, "R2 write all bits", int'(ctrl_rdata), 8'h93);
        check(idle_sysclk_on == 1'b1, "R3 idle bit set", int'(idle_sysclk_on), 1);
        wait_pulses(2, "R4");
        check(gap == 64, "R4 R9 key 0011 runs, same span no restart", gap, 64);

        // R8: periodic clear prevents any request
        p0 = pulses;
        for (int i = 0; i < 20; i++) begin
            step(40);
            sw_clr = 1'b1;
            step(1);
            sw_clr = 1'b0;
        end
        check(pulses == p0, "R8 clear restarts count", pulses - p0, 0);

        // R7: sub-clock strobe every third cycle, sel0 -> 24 cycles
        wr(8'h06);
        src_sel = 1'b0;
        sub_auto = 1'b1;
        wait_pulses(3, "R7");
        check(gap == 24, "R7 sub-clock source", gap, 24);
        sub_auto = 1'b0;
        src_sel = 1'b1;

        // R10: run long, stop, restart -> full period before request
        step(25);
        wr(8'h0A);
        step(10);
        wr(8'h0F);
        p0 = pulses;
        step(28);
        check(pulses == p0, "R10 restart from zero", pulses - p0, 0);
        wait_pulses(1, "R10");
        check(pulses == p0 + 1, "R10 first request after enable", pulses - p0, 1);

        // R5: longest span 2^10 ticks -> 4096 cycles
        wr(8'h7C);
        wait_pulses(2, "R5");
        check(gap == 4096, "R5 longest span", gap, 4096);

        // R4: back to stop key, silence
        wr(8'h7A);
        p0 = pulses;
        step(5000);
        check(pulses == p0, "R4 stopped again", pulses - p0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog: bench timed out actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule